// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave that sits in front of two alias address windows. Every 32-bit word inside a window stands for one bit of a real memory location. A read of an alias word is turned into one downstream read, and the block returns 0 or 1 for the chosen bit. A write of an alias word is turned into a read-modify-write. The real location is fetched, one bit is set or cleared according to bit 0 of the write data, and the result is written back at the same access size.

The slave side carries an address, a size (byte, halfword or word), a write enable and write data. The handshake is valid/ready, and a one-cycle response pulse returns the read bit. The master side issues the downstream reads and writes with its own valid/ready handshake and a response pulse. Data on both sides of the master port is right-justified and little-endian: the byte at the access address sits in bits 7:0. The block only claims addresses inside its two windows. Any other address leaves it idle, so another slave can serve it.

Top module: `bitband_bridge`

## Requirements
- R1: `s_hit` is high exactly when `s_addr[31:25]` equals that of alias base 0x22000000 (window A) or 0x42000000 (window B). A window A hit maps to real base 0x20000000, and a window B hit maps to real base 0x40000000.
- R2: The downstream address is the real base ORed with `s_addr[24:0] >> 5`. It is then aligned by size: byte (`s_size`=0) unchanged, halfword (1) bit 0 cleared, word (2) bits 1:0 cleared. `m_size` equals `s_size`.
- R3: The bit index is `s_addr[4:2]` for a byte, `s_addr[5:2]` for a halfword and `s_addr[6:2]` for a word. Index n selects bit n of the right-justified little-endian value, which is bit n%8 of the byte at real address + n/8.
- R4: An alias read performs exactly one downstream read. It then pulses `s_rsp_valid` with `s_rdata` = 1 if the selected bit is set and 0 otherwise, and all bits of `s_rdata` above bit 0 are zero.
- R5: An alias write performs exactly one downstream read and then one downstream write to the same address. The write sets the selected bit if `s_wdata[0]`=1 and clears it if `s_wdata[0]`=0. Every other bit of the location is unchanged, and `s_wdata[31:1]` has no effect.
- R6: From the cycle after a request is accepted until `s_rsp_valid` pulses, `s_ready` is low and no further request is accepted. `s_rsp_valid` only follows a busy cycle.
- R7: A request whose address is outside both windows causes no downstream request and no response.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_size`, `m_we` and `m_wdata` stay unchanged into the next cycle.
- R9: During and right after synchronous reset, `s_ready` is 1 and both `m_valid` and `s_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave can accept (high when idle) |
| s_hit | output | 1 | Request address lies in an alias window |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_we | input | 1 | 1 write, 0 read |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Selected bit in bit 0, zero elsewhere |
| m_valid | output | 1 | Downstream request valid |
| m_ready | input | 1 | Downstream accepts request |
| m_addr | output | 32 | Real byte address |
| m_size | output | 2 | Downstream access size, same coding |
| m_we | output | 1 | Downstream write enable |
| m_wdata | output | 32 | Right-justified write data |
| m_rsp_valid | input | 1 | Downstream response pulse |
| m_rdata | input | 32 | Right-justified read data |

## Verification
The assertions rely on three things about the inputs. The downstream side returns exactly one response for each accepted request, never in the same cycle as the acceptance. `s_size` never takes the value 3. `m_ready` may drop at any time. The bench's memory model answers one cycle after acceptance and stalls `m_ready` from a pseudo-random sequence. The stimulus sweeps only the three legal sizes, over both windows, the top and bottom of each window, and a further request raised while the block is busy.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bb_state_e;

endpackage

// File: rtl/bb_window_decode.sv
// Compares the alias tag against every window base; the matching window
// supplies its real base (R1).
module bb_window_decode #(
  parameter int ADDR_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] REAL_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:SPAN_LOG2] tag,
  output logic                      hit,
  output logic [ADDR_W-1:0]         real_base
);

  logic [NUM_WIN-1:0] match;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      assign match[w] = (tag == ALIAS_BASE[w][ADDR_W-1:SPAN_LOG2]);
    end
  endgenerate

  always_comb begin
    real_base = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match[i]) real_base = real_base | REAL_BASE[i];
    end
  end

  assign hit = |match;

endmodule

// File: rtl/bb_addr_xlate.sv
// Alias offset -> real byte address and bit index (R2, R3).
module bb_addr_xlate import bb_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 25,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0]      real_base,
  input  logic [SPAN_LOG2-1:2]   word_off,
  input  logic [1:0]             size,
  output logic [ADDR_W-1:0]      real_addr,
  output logic [IDX_W-1:0]       bit_idx
);

  localparam int OFF_W    = SPAN_LOG2 - 2;
  localparam int BYTE_SH  = 3;
  localparam logic [IDX_W-1:0] IDX_MASK_B = IDX_W'(7);
  localparam logic [IDX_W-1:0] IDX_MASK_H = IDX_W'(15);
  localparam logic [ADDR_W-1:0] ALIGN_H = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALIGN_W = ~ADDR_W'(3);

  logic [OFF_W-1:0]  off_vec;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] byte_addr;
  logic [IDX_W-1:0]  raw_idx;

  assign off_vec   = word_off;
  assign off_ext   = {{(ADDR_W-OFF_W){1'b0}}, off_vec};
  assign byte_addr = real_base | (off_ext >> BYTE_SH);
  assign raw_idx   = off_vec[IDX_W-1:0];

  always_comb begin
    case (bb_size_e'(size))
      SZ_BYTE: begin
        real_addr = byte_addr;
        bit_idx   = raw_idx & IDX_MASK_B;
      end
      SZ_HALF: begin
        real_addr = byte_addr & ALIGN_H;
        bit_idx   = raw_idx & IDX_MASK_H;
      end
      default: begin
        real_addr = byte_addr & ALIGN_W;
        bit_idx   = raw_idx;
      end
    endcase
  end

endmodule

// File: rtl/bb_bit_merge.sv
// Picks the addressed bit out of the fetched value and forms the value to
// write back, limited to the access width (R3, R5).
module bb_bit_merge import bb_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        size,
  input  logic [IDX_W-1:0]  idx,
  input  logic              set_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] merged
);

  localparam logic [DATA_W-1:0] LANE_B = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] LANE_H = {{(DATA_W-16){1'b0}}, 16'hFFFF};

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] lane;
  logic [DATA_W-1:0] updated;

  assign sel     = DATA_W'(1) << idx;
  assign bit_out = |(rdata & sel);
  assign updated = set_val ? (rdata | sel) : (rdata & ~sel);

  always_comb begin
    case (bb_size_e'(size))
      SZ_BYTE: lane = LANE_B;
      SZ_HALF: lane = LANE_H;
      default: lane = '1;
    endcase
  end

  assign merged = updated & lane;

endmodule

// File: rtl/bb_rmw_fsm.sv
// Three-state sequencer: IDLE accepts, READ fetches, WRITE stores the
// merged value (R4, R5, R6, R8).
module bb_rmw_fsm import bb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic              req_we,
  input  logic              req_wbit,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              ready,
  output logic              rsp_valid,
  output logic              rsp_bit,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic              m_we,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_rsp_valid,
  input  logic [DATA_W-1:0] m_rdata
);

  bb_state_e         state_q;
  logic              we_q;
  logic              wbit_q;
  logic [IDX_W-1:0]  idx_q;
  logic              m_valid_q;
  logic              m_we_q;
  logic [ADDR_W-1:0] m_addr_q;
  logic [1:0]        m_size_q;
  logic [DATA_W-1:0] m_wdata_q;
  logic              rsp_valid_q;
  logic              rsp_bit_q;

  logic              cur_bit;
  logic [DATA_W-1:0] new_val;
  logic              dn_done;

  bb_bit_merge #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_merge (
    .rdata   (m_rdata),
    .size    (m_size_q),
    .idx     (idx_q),
    .set_val (wbit_q),
    .bit_out (cur_bit),
    .merged  (new_val)
  );

  // a response only counts once the request has left the port
  assign dn_done = m_rsp_valid && !m_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      we_q        <= 1'b0;
      wbit_q      <= 1'b0;
      idx_q       <= '0;
      m_valid_q   <= 1'b0;
      m_we_q      <= 1'b0;
      m_addr_q    <= '0;
      m_size_q    <= '0;
      m_wdata_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_bit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (m_valid_q && m_ready) m_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid && req_hit) begin
            we_q      <= req_we;
            wbit_q    <= req_wbit;
            idx_q     <= req_idx;
            m_addr_q  <= req_addr;
            m_size_q  <= req_size;
            m_we_q    <= 1'b0;
            m_wdata_q <= '0;
            m_valid_q <= 1'b1;
            state_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (dn_done) begin
            if (we_q) begin
              m_wdata_q <= new_val;
              m_we_q    <= 1'b1;
              m_valid_q <= 1'b1;
              state_q   <= ST_WRITE;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_bit_q   <= cur_bit;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          if (dn_done) begin
            rsp_valid_q <= 1'b1;
            rsp_bit_q   <= 1'b0;
            m_we_q      <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready     = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_bit   = rsp_bit_q;
  assign m_valid   = m_valid_q;
  assign m_addr    = m_addr_q;
  assign m_size    = m_size_q;
  assign m_we      = m_we_q;
  assign m_wdata   = m_wdata_q;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] REAL_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              s_hit,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [1:0]        s_size,
  input  logic              s_we,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_rsp_valid,
  output logic [DATA_W-1:0] s_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic              m_we,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_rsp_valid,
  input  logic [DATA_W-1:0] m_rdata
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] win_real_base;
  logic [ADDR_W-1:0] xl_addr;
  logic [IDX_W-1:0]  xl_idx;
  logic              rsp_bit;
  logic              unused_top;

  assign unused_top = ^{s_wdata[DATA_W-1:1], s_addr[1:0]};

  bb_window_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_WIN    (NUM_WIN),
    .SPAN_LOG2  (SPAN_LOG2),
    .ALIAS_BASE (ALIAS_BASE),
    .REAL_BASE  (REAL_BASE)
  ) u_decode (
    .tag       (s_addr[ADDR_W-1:SPAN_LOG2]),
    .hit       (s_hit),
    .real_base (win_real_base)
  );

  bb_addr_xlate #(
    .ADDR_W    (ADDR_W),
    .SPAN_LOG2 (SPAN_LOG2),
    .IDX_W     (IDX_W)
  ) u_xlate (
    .real_base (win_real_base),
    .word_off  (s_addr[SPAN_LOG2-1:2]),
    .size      (s_size),
    .real_addr (xl_addr),
    .bit_idx   (xl_idx)
  );

  bb_rmw_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (s_valid),
    .req_hit     (s_hit),
    .req_we      (s_we),
    .req_wbit    (s_wdata[0]),
    .req_size    (s_size),
    .req_addr    (xl_addr),
    .req_idx     (xl_idx),
    .ready       (s_ready),
    .rsp_valid   (s_rsp_valid),
    .rsp_bit     (rsp_bit),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_addr      (m_addr),
    .m_size      (m_size),
    .m_we        (m_we),
    .m_wdata     (m_wdata),
    .m_rsp_valid (m_rsp_valid),
    .m_rdata     (m_rdata)
  );

  assign s_rdata = {{(DATA_W-1){1'b0}}, rsp_bit};

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_LOG2 = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] REAL_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_hit,
  input logic              s_rsp_valid,
  input logic [DATA_W-1:0] s_rdata,
  input logic              m_valid,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic [1:0]        m_size,
  input logic              m_we,
  input logic [DATA_W-1:0] m_wdata
);

  logic real_ok;

  always_comb begin
    real_ok = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (m_addr[ADDR_W-1:SPAN_LOG2] == REAL_BASE[i][ADDR_W-1:SPAN_LOG2]) real_ok = 1'b1;
    end
  end

  a_r1_real_region: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> real_ok);

  a_r2_half_align: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_size == 2'd1) |-> (m_addr[0] == 1'b0));

  a_r2_word_align: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00));

  a_r4_rdata_single_bit: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> ((s_rdata >> 1) == '0));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_hit && s_ready) |=> !s_ready);

  a_r6_rsp_after_busy: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> $past(!s_ready));

  a_r7_unclaimed_quiet: assert property (@(posedge clk) disable iff (rst)
    (s_ready && !(s_valid && s_hit)) |=> !m_valid);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_size)
                               && $stable(m_we) && $stable(m_wdata)));

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_WIN   (NUM_WIN),
  .SPAN_LOG2 (SPAN_LOG2),
  .REAL_BASE (REAL_BASE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .s_hit       (s_hit),
  .s_rsp_valid (s_rsp_valid),
  .s_rdata     (s_rdata),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_addr      (m_addr),
  .m_size      (m_size),
  .m_we        (m_we),
  .m_wdata     (m_wdata)
);

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;

  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid;
  logic        s_ready;
  logic        s_hit;
  logic [31:0] s_addr;
  logic [1:0]  s_size;
  logic        s_we;
  logic [31:0] s_wdata;
  logic        s_rsp_valid;
  logic [31:0] s_rdata;
  logic        m_valid;
  logic        m_ready;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic        m_we;
  logic [31:0] m_wdata;
  logic        m_rsp_valid;
  logic [31:0] m_rdata;

  always #2 clk = ~clk;

  bitband_bridge dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_hit(s_hit),
    .s_addr(s_addr), .s_size(s_size), .s_we(s_we), .s_wdata(s_wdata),
    .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata), .m_valid(m_valid),
    .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size), .m_we(m_we),
    .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid), .m_rdata(m_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // ---------------- downstream memory model ----------------
  logic [7:0]  mem     [2][256];
  logic [7:0]  exp_mem [2][256];
  logic [15:0] lfsr;
  int          acc_cnt;
  logic [31:0] last_addr;
  logic [1:0]  last_size;
  int          hold_bad;
  logic        prev_stall;
  logic [31:0] prev_addr;
  logic [31:0] prev_wdata;
  logic [1:0]  prev_size;
  logic        prev_we;

  function automatic logic [7:0] init_pat(int w, int i);
    return 8'((i * 37 + 11 + w * 90) & 255);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lfsr        <= 16'hACE1;
      m_ready     <= 1'b0;
      m_rsp_valid <= 1'b0;
      m_rdata     <= '0;
      acc_cnt     <= 0;
      hold_bad    <= 0;
      prev_stall  <= 1'b0;
      last_addr   <= '0;
      last_size   <= '0;
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 256; i++) mem[w][i] = init_pat(w, i);
    end else begin
      lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready     <= lfsr[0] | lfsr[2];
      m_rsp_valid <= 1'b0;
      if (prev_stall && !(m_valid && m_addr == prev_addr && m_wdata == prev_wdata
                          && m_size == prev_size && m_we == prev_we))
        hold_bad <= hold_bad + 1;
      prev_stall <= m_valid && !m_ready;
      prev_addr  <= m_addr;
      prev_wdata <= m_wdata;
      prev_size  <= m_size;
      prev_we    <= m_we;
      if (m_valid && m_ready) begin
        logic [31:0] rd;
        acc_cnt     <= acc_cnt + 1;
        last_addr   <= m_addr;
        last_size   <= m_size;
        m_rsp_valid <= 1'b1;
        rd = '0;
        for (int i = 0; i < (1 << m_size); i++) begin
          logic [7:0] bi;
          bi = m_addr[7:0] + 8'(i);
          if (m_we) mem[m_addr[30]][bi] = m_wdata[8*i +: 8];
          else      rd = rd | (32'(mem[m_addr[30]][bi]) << (8 * i));
        end
        m_rdata <= rd;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] alias_base(int w);
    return (w != 0) ? 32'h4200_0000 : 32'h2200_0000;
  endfunction

  function automatic logic [31:0] exp_real(int w, logic [31:0] off, int sz);
    logic [31:0] r;
    r = ((w != 0) ? 32'h4000_0000 : 32'h2000_0000) | ((off & 32'h01FF_FFFF) >> 5);
    if (sz == 1) r = r & ~32'd1;
    if (sz == 2) r = r & ~32'd3;
    return r;
  endfunction

  function automatic int exp_idx(logic [31:0] off, int sz);
    return int'((off >> 2) & 32'((8 << sz) - 1));
  endfunction

  task automatic access(input logic [31:0] addr, input int sz, input bit we,
                        input logic [31:0] wdata, input bit noise,
                        output logic [31:0] rdata, output int nacc);
    int c0;
    int guard;
    c0 = acc_cnt;
    @(negedge clk);
    s_valid = 1'b1; s_addr = addr; s_size = 2'(sz); s_we = we; s_wdata = wdata;
    @(negedge clk);
    s_valid = 1'b0;
    if (noise) begin
      s_valid = 1'b1; s_addr = addr ^ 32'h0000_1000; s_we = 1'b1; s_wdata = 32'h1;
    end
    guard = 0;
    while (!s_rsp_valid && guard < 1000) begin
      check(!s_ready, "R6 ready low while busy", 32'(s_ready), 32'd0);
      @(negedge clk);
      guard++;
    end
    s_valid = 1'b0;
    check(s_rsp_valid, "R6 response arrives", 32'(s_rsp_valid), 32'd1);
    check(s_ready, "R6 ready back with response", 32'(s_ready), 32'd1);
    rdata = s_rdata;
    nacc  = acc_cnt - c0;
  endtask

  task automatic mem_compare(input string req);
    int bad;
    bad = 0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 256; i++)
        if (mem[w][i] !== exp_mem[w][i]) bad++;
    check(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic do_write(input int w, input logic [31:0] off, input int sz,
                          input bit wbit, input logic [31:0] upper, input bit noise);
    logic [31:0] rd;
    logic [31:0] ra;
    logic [7:0]  bidx;
    int          nacc;
    int          ix;
    access(alias_base(w) | off, sz, 1'b1, (upper & ~32'd1) | 32'(wbit), noise, rd, nacc);
    ra = exp_real(w, off, sz);
    ix = exp_idx(off, sz);
    check(nacc == 2, "R5 read then write count", 32'(nacc), 32'd2);
    check(last_addr == ra, "R2 write address", last_addr, ra);
    check(last_size == 2'(sz), "R2 write size", 32'(last_size), 32'(sz));
    bidx = ra[7:0] + 8'(ix / 8);
    exp_mem[w][bidx][ix % 8] = wbit;
    mem_compare("R5 R3 memory after write");
  endtask

  task automatic do_read(input int w, input logic [31:0] off, input int sz);
    logic [31:0] rd;
    logic [31:0] ra;
    logic [7:0]  bidx;
    int          nacc;
    int          ix;
    access(alias_base(w) | off, sz, 1'b0, 32'hFFFF_FFFF, 1'b0, rd, nacc);
    ra = exp_real(w, off, sz);
    ix = exp_idx(off, sz);
    bidx = ra[7:0] + 8'(ix / 8);
    check(nacc == 1, "R4 single read", 32'(nacc), 32'd1);
    check(last_addr == ra, "R2 read address", last_addr, ra);
    check(last_size == 2'(sz), "R4 read size", 32'(last_size), 32'(sz));
    check(rd == 32'(exp_mem[w][bidx][ix % 8]), "R4 R3 read bit", rd,
          32'(exp_mem[w][bidx][ix % 8]));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] edge_offs [4];
    logic [31:0] out_addrs [5];
    logic [31:0] in_addrs  [4];
    edge_offs = '{32'h01FF_FFFC, 32'h01FF_FFE0, 32'h0100_0004, 32'h0000_007C};
    out_addrs = '{32'h21FF_FFFF, 32'h2400_0000, 32'h41FF_FFFC, 32'h4400_0000, 32'h0200_0000};
    in_addrs  = '{32'h2200_0000, 32'h23FF_FFFC, 32'h4200_0000, 32'h43FF_FFFF};

    rst = 1'b1; s_valid = 1'b0; s_addr = '0; s_size = 2'd0; s_we = 1'b0; s_wdata = '0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 256; i++) exp_mem[w][i] = init_pat(w, i);
    repeat (3) @(negedge clk);
    check(s_ready, "R9 ready in reset", 32'(s_ready), 32'd1);
    check(!m_valid, "R9 no request in reset", 32'(m_valid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(s_ready, "R9 ready after reset", 32'(s_ready), 32'd1);
    check(!m_valid, "R9 m_valid low after reset", 32'(m_valid), 32'd0);
    check(!s_rsp_valid, "R9 no response after reset", 32'(s_rsp_valid), 32'd0);

    // R1: window decode at the window edges
    foreach (in_addrs[i]) begin
      s_addr = in_addrs[i]; #1;
      check(s_hit, "R1 inside window", 32'(s_hit), 32'd1);
    end
    foreach (out_addrs[i]) begin
      s_addr = out_addrs[i]; #1;
      check(!s_hit, "R1 outside window", 32'(s_hit), 32'd0);
    end

    // R7: unclaimed requests leave the downstream port idle
    foreach (out_addrs[i]) begin
      int c0;
      int seen;
      c0 = acc_cnt;
      seen = 0;
      @(negedge clk);
      s_valid = 1'b1; s_addr = out_addrs[i]; s_we = i[0]; s_size = 2'd2; s_wdata = 32'h1;
      repeat (4) begin
        @(negedge clk);
        if (m_valid || s_rsp_valid || !s_ready) seen++;
      end
      s_valid = 1'b0;
      @(negedge clk);
      check(seen == 0, "R7 no activity for unclaimed address", 32'(seen), 32'd0);
      check(acc_cnt == c0, "R7 no downstream request", 32'(acc_cnt - c0), 32'd0);
    end
    mem_compare("R7 memory untouched");

    // Sweep: both windows, every size, every bit of the low locations
    for (int w = 0; w < 2; w++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int k = 0; k < 256; k++) begin
          logic [31:0] off;
          bit          wb;
          off = 32'(k * 4);
          wb  = ((k * 5 + sz + w) % 3) != 0;
          do_write(w, off, sz, wb, 32'hDEAD_BEE0 ^ 32'(k << 8), 1'b0);
          do_read(w, off, sz);
        end
      end
    end

    // Top and middle of each window, set then clear
    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 3; sz++)
        foreach (edge_offs[j]) begin
          do_write(w, edge_offs[j], sz, 1'b1, 32'h0, 1'b0);
          do_read(w, edge_offs[j], sz);
          do_write(w, edge_offs[j], sz, 1'b0, 32'hFFFF_FFFE, 1'b0);
          do_read(w, edge_offs[j], sz);
        end

    // R6: a second request held during a busy write is not taken
    for (int k = 0; k < 8; k++) begin
      do_write(k % 2, 32'(k * 36), 2, k[1], 32'h0, 1'b1);
      do_read(k % 2, 32'(k * 36), 2);
    end

    repeat (4) @(negedge clk);
    check(hold_bad == 0, "R8 request stable under stall", 32'(hold_bad), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule